// File: doc/BRIEF.md
# Interrupt Event Routing Engine

The block accepts forwarded interrupt events, each carrying a source number and 31 bits of event data. Each event is resolved in two steps. The source number selects an assignment entry. That entry names a notification descriptor. The descriptor supplies a target identifier, a 3-bit priority (eight levels) and a ring-shaped region of a small on-chip event queue. Every routed event writes one queue entry for software to pull. It also raises a one-cycle notification, carrying target and priority, towards the presentation stage.

Events that hit an invalid or masked assignment, or an invalid descriptor, are dropped and counted. Both tables are loaded through two simple write ports, one for each table. A read port exposes any queue word so that the consumer can drain the queue. Table sizes, queue depth, target width and counter width are parameters.

Top module: `evt_router`

## Requirements
- R1: After reset, `ntf_valid` is 0, `drop_cnt` is 0, every queue word reads 0, and every assignment and descriptor entry is invalid.
- R2: An event presented with `ev_valid` in cycle N, whose assignment entry is valid and unmasked and whose descriptor is valid, raises `ntf_valid` for exactly one cycle in cycle N+2. In that cycle `ntf_tgt` and `ntf_prio` carry the descriptor's target and priority.
- R3: An event whose assignment entry is invalid or masked writes no queue word and raises no notification. It increments `drop_cnt` by one, visible in cycle N+2.
- R4: An event whose assignment selects an invalid descriptor is dropped in the same way as in R3.
- R5: A routed event writes the word {gen, data[30:0]} at queue address (base + wp) mod 2^QAW. The generation flag is bit 31, and base and wp are taken from the descriptor.
- R6: After each routed event the descriptor's write pointer advances by one. After the entry at wp = len-1 it returns to 0 and the generation flag inverts. A descriptor write sets wp to 0 and the flag to 1.
- R7: Events to the same descriptor in consecutive cycles occupy consecutive queue slots, with no slot skipped or reused.
- R8: A table write in cycle N applies to events presented in cycle N+1 or later. An event presented in the same cycle as an assignment write to its own source still uses the old entry.
- R9: When a descriptor write and a pointer update for the same descriptor land on the same clock edge, the descriptor write wins. The event still writes its queue word and raises its notification using the old descriptor contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Event present this cycle |
| ev_src | input | SRC_W | Source number of the event |
| ev_data | input | 31 | Event data stored in the queue word |
| asg_we | input | 1 | Assignment table write strobe |
| asg_idx | input | SRC_W | Assignment entry to write |
| asg_vld | input | 1 | Valid bit written to the entry |
| asg_mask | input | 1 | Mask bit written to the entry |
| asg_dsc | input | DSC_W | Descriptor index written to the entry |
| dsc_we | input | 1 | Descriptor table write strobe |
| dsc_idx | input | DSC_W | Descriptor to write |
| dsc_vld | input | 1 | Valid bit written to the descriptor |
| dsc_tgt | input | TGT_W | Notification target |
| dsc_prio | input | 3 | Priority, 0 to 7 |
| dsc_base | input | QAW | First queue address of the descriptor's ring |
| dsc_len | input | QAW+1 | Ring length in entries, 1 to 2^QAW |
| ntf_valid | output | 1 | One-cycle notification strobe |
| ntf_tgt | output | TGT_W | Target of the notification |
| ntf_prio | output | 3 | Priority of the notification |
| drop_cnt | output | CNT_W | Count of dropped events, wraps |
| qrd_addr | input | QAW | Queue read address |
| qrd_data | output | 32 | Queue word at `qrd_addr`, combinational |

## Verification
Assertions check four properties on every cycle. Each descriptor's write pointer stays inside its ring. A notification and a drop never come from the same edge. The drop count grows by at most one per cycle. Every notification follows an event presented two cycles earlier. The bench scenarios cover the rest: the queue addresses and generation flags across wraps, back-to-back pointer forwarding, the old-versus-new table semantics when writes coincide with events, and the descriptor write overriding an in-flight pointer update. These are checked against a cycle-ordered reference model that runs under random traffic and random reconfiguration.

// File: rtl/evt_router.sv
module evt_router #(
  parameter int SRC_W = 4,
  parameter int DSC_W = 2,
  parameter int QAW   = 5,
  parameter int TGT_W = 6,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_valid,
  input  logic [SRC_W-1:0] ev_src,
  input  logic [30:0]      ev_data,
  input  logic             asg_we,
  input  logic [SRC_W-1:0] asg_idx,
  input  logic             asg_vld,
  input  logic             asg_mask,
  input  logic [DSC_W-1:0] asg_dsc,
  input  logic             dsc_we,
  input  logic [DSC_W-1:0] dsc_idx,
  input  logic             dsc_vld,
  input  logic [TGT_W-1:0] dsc_tgt,
  input  logic [2:0]       dsc_prio,
  input  logic [QAW-1:0]   dsc_base,
  input  logic [QAW:0]     dsc_len,
  output logic             ntf_valid,
  output logic [TGT_W-1:0] ntf_tgt,
  output logic [2:0]       ntf_prio,
  output logic [CNT_W-1:0] drop_cnt,
  input  logic [QAW-1:0]   qrd_addr,
  output logic [31:0]      qrd_data
);
  localparam int NSRC = 1 << SRC_W;
  localparam int NDSC = 1 << DSC_W;
  localparam int QDEP = 1 << QAW;
  localparam logic [CNT_W-1:0] CNT_ONE = 1;

  logic             a_vld [NSRC];
  logic             a_msk [NSRC];
  logic [DSC_W-1:0] a_dsc [NSRC];

  logic             d_vld  [NDSC];
  logic [TGT_W-1:0] d_tgt  [NDSC];
  logic [2:0]       d_prio [NDSC];
  logic [QAW-1:0]   d_base [NDSC];
  logic [QAW:0]     d_len  [NDSC];
  logic [QAW-1:0]   d_wp   [NDSC];
  logic             d_gen  [NDSC];

  logic [31:0] qmem [QDEP];

  logic             s1_valid, s1_ok;
  logic [DSC_W-1:0] s1_dsc;
  logic [30:0]      s1_data;

  logic           hit, last;
  logic [QAW-1:0] wr_addr;
  logic [QAW:0]   len_m1;

  assign hit      = s1_valid & s1_ok & d_vld[s1_dsc];
  assign len_m1   = d_len[s1_dsc] - 1'b1;
  assign last     = ({1'b0, d_wp[s1_dsc]} == len_m1);
  assign wr_addr  = d_base[s1_dsc] + d_wp[s1_dsc];
  assign qrd_data = qmem[qrd_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSRC; i++) begin
        a_vld[i] <= 1'b0;
        a_msk[i] <= 1'b0;
        a_dsc[i] <= '0;
      end
    end else if (asg_we) begin
      a_vld[asg_idx] <= asg_vld;
      a_msk[asg_idx] <= asg_mask;
      a_dsc[asg_idx] <= asg_dsc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_ok    <= 1'b0;
      s1_dsc   <= '0;
      s1_data  <= '0;
    end else begin
      s1_valid <= ev_valid;
      s1_ok    <= a_vld[ev_src] & ~a_msk[ev_src];
      s1_dsc   <= a_dsc[ev_src];
      s1_data  <= ev_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NDSC; i++) begin
        d_vld[i]  <= 1'b0;
        d_tgt[i]  <= '0;
        d_prio[i] <= '0;
        d_base[i] <= '0;
        d_len[i]  <= '0;
        d_wp[i]   <= '0;
        d_gen[i]  <= 1'b1;
      end
    end else begin
      if (hit) begin
        d_wp[s1_dsc]  <= last ? '0 : d_wp[s1_dsc] + 1'b1;
        d_gen[s1_dsc] <= d_gen[s1_dsc] ^ last;
      end
      if (dsc_we) begin
        d_vld[dsc_idx]  <= dsc_vld;
        d_tgt[dsc_idx]  <= dsc_tgt;
        d_prio[dsc_idx] <= dsc_prio;
        d_base[dsc_idx] <= dsc_base;
        d_len[dsc_idx]  <= dsc_len;
        d_wp[dsc_idx]   <= '0;
        d_gen[dsc_idx]  <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < QDEP; i++) qmem[i] <= '0;
    end else if (hit) begin
      qmem[wr_addr] <= {d_gen[s1_dsc], s1_data};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ntf_valid <= 1'b0;
      ntf_tgt   <= '0;
      ntf_prio  <= '0;
      drop_cnt  <= '0;
    end else begin
      ntf_valid <= hit;
      ntf_tgt   <= d_tgt[s1_dsc];
      ntf_prio  <= d_prio[s1_dsc];
      if (s1_valid && !hit) drop_cnt <= drop_cnt + CNT_ONE;
    end
  end

  for (genvar g = 0; g < NDSC; g++) begin : g_wp_chk
    // R6
    wp_in_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (d_vld[g] && d_len[g] != '0) |-> ({1'b0, d_wp[g]} < d_len[g]));
  end

  // R3
  ntf_no_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ntf_valid |-> (drop_cnt == $past(drop_cnt)));

  // R4
  drop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((drop_cnt - $past(drop_cnt)) <= CNT_ONE));

  // R2
  ntf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ntf_valid |-> $past(ev_valid, 2));
endmodule

// File: tb/test_evt_router.sv
module test_evt_router;
  localparam int SRC_W = 4, DSC_W = 2, QAW = 5, TGT_W = 6, CNT_W = 16;
  localparam int NSRC = 1 << SRC_W, NDSC = 1 << DSC_W, QDEP = 1 << QAW;

  logic clk = 0, rst_n = 0;
  logic ev_valid = 0; logic [SRC_W-1:0] ev_src = 0; logic [30:0] ev_data = 0;
  logic asg_we = 0; logic [SRC_W-1:0] asg_idx = 0; logic asg_vld = 0, asg_mask = 0;
  logic [DSC_W-1:0] asg_dsc = 0;
  logic dsc_we = 0; logic [DSC_W-1:0] dsc_idx = 0; logic dsc_vld = 0;
  logic [TGT_W-1:0] dsc_tgt = 0; logic [2:0] dsc_prio = 0;
  logic [QAW-1:0] dsc_base = 0; logic [QAW:0] dsc_len = 0;
  logic ntf_valid; logic [TGT_W-1:0] ntf_tgt; logic [2:0] ntf_prio;
  logic [CNT_W-1:0] drop_cnt; logic [QAW-1:0] qrd_addr = 0; logic [31:0] qrd_data;

  evt_router #(.SRC_W(SRC_W), .DSC_W(DSC_W), .QAW(QAW), .TGT_W(TGT_W), .CNT_W(CNT_W)) i_evt_router (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_src(ev_src), .ev_data(ev_data),
    .asg_we(asg_we), .asg_idx(asg_idx), .asg_vld(asg_vld), .asg_mask(asg_mask), .asg_dsc(asg_dsc),
    .dsc_we(dsc_we), .dsc_idx(dsc_idx), .dsc_vld(dsc_vld), .dsc_tgt(dsc_tgt), .dsc_prio(dsc_prio),
    .dsc_base(dsc_base), .dsc_len(dsc_len), .ntf_valid(ntf_valid), .ntf_tgt(ntf_tgt),
    .ntf_prio(ntf_prio), .drop_cnt(drop_cnt), .qrd_addr(qrd_addr), .qrd_data(qrd_data));

  always #5 clk = ~clk;

  int tests = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // reference model
  bit m_av [NSRC]; bit m_am [NSRC]; int m_ad [NSRC];
  bit m_dv [NDSC]; int m_dt [NDSC]; int m_dp [NDSC]; int m_db [NDSC];
  int m_dl [NDSC]; int m_wp [NDSC]; bit m_gen [NDSC];
  logic [31:0] m_q [QDEP];
  int m_drop = 0;
  bit p_v = 0, p_ok = 0; int p_d = 0; logic [30:0] p_data = 0;
  bit e_v = 0; int e_t = 0, e_p = 0;

  // next-cycle stimulus
  bit g_ev = 0; int g_src = 0; logic [30:0] g_data = 0;
  bit g_awe = 0; int g_aidx = 0; bit g_avld = 0, g_amsk = 0; int g_adsc = 0;
  bit g_dwe = 0; int g_didx = 0; bit g_dvld = 0; int g_dtgt = 0, g_dprio = 0, g_dbase = 0, g_dlen = 1;

  task automatic tick();
    int addr;
    @(negedge clk);
    chk(ntf_valid == e_v, "R2", ntf_valid, e_v);
    if (e_v) begin
      chk(ntf_tgt == TGT_W'(e_t), "R2", ntf_tgt, e_t);
      chk(ntf_prio == 3'(e_p), "R2", ntf_prio, e_p);
    end
    chk(drop_cnt == CNT_W'(m_drop), "R3 R4", drop_cnt, m_drop);
    e_v = 0;
    if (p_v) begin
      if (p_ok && m_dv[p_d]) begin
        addr = (m_db[p_d] + m_wp[p_d]) % QDEP;
        m_q[addr] = {m_gen[p_d], p_data};
        e_v = 1; e_t = m_dt[p_d]; e_p = m_dp[p_d];
        if (m_wp[p_d] == m_dl[p_d] - 1) begin m_wp[p_d] = 0; m_gen[p_d] = ~m_gen[p_d]; end
        else m_wp[p_d]++;
      end else m_drop++;
    end
    if (g_dwe) begin
      m_dv[g_didx] = g_dvld; m_dt[g_didx] = g_dtgt; m_dp[g_didx] = g_dprio;
      m_db[g_didx] = g_dbase; m_dl[g_didx] = g_dlen; m_wp[g_didx] = 0; m_gen[g_didx] = 1;
    end
    p_v = g_ev; p_ok = m_av[g_src] & ~m_am[g_src]; p_d = m_ad[g_src]; p_data = g_data;
    if (g_awe) begin m_av[g_aidx] = g_avld; m_am[g_aidx] = g_amsk; m_ad[g_aidx] = g_adsc; end
    ev_valid = g_ev; ev_src = SRC_W'(g_src); ev_data = g_data;
    asg_we = g_awe; asg_idx = SRC_W'(g_aidx); asg_vld = g_avld; asg_mask = g_amsk; asg_dsc = DSC_W'(g_adsc);
    dsc_we = g_dwe; dsc_idx = DSC_W'(g_didx); dsc_vld = g_dvld; dsc_tgt = TGT_W'(g_dtgt);
    dsc_prio = 3'(g_dprio); dsc_base = QAW'(g_dbase); dsc_len = (QAW+1)'(g_dlen);
    g_ev = 0; g_awe = 0; g_dwe = 0;
  endtask

  task automatic set_ev(input int s, input logic [30:0] d);
    g_ev = 1; g_src = s; g_data = d;
  endtask
  task automatic set_asg(input int i, input bit v, input bit m, input int d);
    g_awe = 1; g_aidx = i; g_avld = v; g_amsk = m; g_adsc = d;
  endtask
  task automatic set_dsc(input int i, input bit v, input int t, input int p, input int b, input int l);
    g_dwe = 1; g_didx = i; g_dvld = v; g_dtgt = t; g_dprio = p; g_dbase = b; g_dlen = l;
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask
  task automatic rdq(input int a, input logic [31:0] exp, input string req);
    qrd_addr = QAW'(a); #1;
    chk(qrd_data == exp, req, qrd_data, exp);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int base0;
    void'($urandom(32'd2024));
    for (int i = 0; i < NSRC; i++) begin m_av[i] = 0; m_am[i] = 0; m_ad[i] = 0; end
    for (int i = 0; i < NDSC; i++) begin
      m_dv[i] = 0; m_dt[i] = 0; m_dp[i] = 0; m_db[i] = 0; m_dl[i] = 0; m_wp[i] = 0; m_gen[i] = 1;
    end
    for (int i = 0; i < QDEP; i++) m_q[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(ntf_valid == 0, "R1", ntf_valid, 0);
    chk(drop_cnt == 0, "R1", drop_cnt, 0);
    rdq(0, 0, "R1"); rdq(QDEP-1, 0, "R1");
    set_ev(1, 31'h1); tick(); idle(2);
    chk(drop_cnt == 1, "R1", drop_cnt, 1);

    // ring at base 30, len 3: addresses 30,31,0 then 30 again (R5 R6 R7)
    set_dsc(0, 1, 5, 3, 30, 3); set_asg(2, 1, 0, 0); tick();
    set_ev(2, 31'h11); tick();
    set_ev(2, 31'h12); tick();
    set_ev(2, 31'h13); tick();
    set_ev(2, 31'h14); tick();
    idle(3);
    rdq(31, {1'b1, 31'h12}, "R7");
    rdq(0,  {1'b1, 31'h13}, "R5");
    rdq(30, {1'b0, 31'h14}, "R6");

    // R3 masked, R4 invalid descriptor
    set_asg(3, 1, 1, 0); tick();
    set_ev(3, 31'h21); tick(); idle(3);
    chk(drop_cnt == 2, "R3", drop_cnt, 2);
    set_asg(4, 1, 0, 1); tick();
    set_ev(4, 31'h22); tick(); idle(3);
    chk(drop_cnt == 3, "R4", drop_cnt, 3);

    // R8: same-cycle write uses old entry, next-cycle event sees new one
    set_asg(6, 1, 0, 0); set_ev(6, 31'h60); tick(); idle(3);
    chk(drop_cnt == 4, "R8", drop_cnt, 4);
    set_asg(5, 1, 0, 0); tick();
    set_ev(5, 31'h55); tick(); idle(3);
    rdq(31, {1'b0, 31'h55}, "R8");
    chk(drop_cnt == 4, "R8", drop_cnt, 4);

    // R9: descriptor rewrite lands with pointer update; rewrite wins
    set_ev(2, 31'h66); tick();
    set_dsc(0, 1, 7, 1, 8, 4); tick();
    set_ev(2, 31'h77); tick(); idle(3);
    rdq(0, {1'b0, 31'h66}, "R9");
    rdq(8, {1'b1, 31'h77}, "R9");

    // random configuration and traffic
    for (int i = 0; i < NDSC; i++) begin
      set_dsc(i, ($urandom % 8) != 0, $urandom % 64, $urandom % 8, $urandom % QDEP, 1 + $urandom % 8);
      tick();
    end
    for (int i = 0; i < NSRC; i++) begin
      set_asg(i, ($urandom % 5) != 0, ($urandom % 7) == 0, $urandom % NDSC);
      tick();
    end
    for (int n = 0; n < 4000; n++) begin
      if ($urandom % 10 < 6) set_ev($urandom % NSRC, 31'($urandom));
      if ($urandom % 100 < 3) set_asg($urandom % NSRC, ($urandom % 5) != 0, ($urandom % 7) == 0, $urandom % NDSC);
      if ($urandom % 100 < 2) begin
        base0 = $urandom % QDEP;
        set_dsc($urandom % NDSC, ($urandom % 8) != 0, $urandom % 64, $urandom % 8, base0, 1 + $urandom % QDEP);
      end
      tick();
    end
    idle(3);
    for (int a = 0; a < QDEP; a++) rdq(a, m_q[a], "R5");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule